// File: doc/BRIEF.md
# Dual-Line Line-Code Decoder with Per-Rule Violation Flags

This block sits at the receiving end of a two-wire line code. A serial source is split by the transmitter onto two wires: a 1 travels on one wire or the other, never on both at once. A run of four zero bits is replaced by a fixed four-symbol substitution group. The decoder takes the two wires, rebuilds the serial bit stream, and turns every substitution group back into four zero bits.

At the same time it checks the wires against the coding rules. Each broken rule drives its own one-cycle flag, and a combined error output is raised whenever any flag is raised. The rules are: both wires high together, a 1 on the same wire in two cycles in a row, and a run of four or more all-zero symbols. Each wire feeds a four-stage window, so a substitution group can be recognised in full before its first symbol is decoded. Legal substitution symbols are therefore never reported as violations. The flags only report problems; they do not repair the data.

Top module: `dl_decoder`

## Requirements
- R1: An asynchronous active-low reset clears the data output and every flag. After reset is released, the first four clock edges produce no data 1 and no flag, because the window still holds reset fill and not received symbols.
- R2: A symbol sampled at clock edge k is decoded at edge k+4. Outside a substitution group, the data output is 1 when exactly one wire was 1 and 0 when both wires were 0.
- R3: A substitution group is four symbols that read, oldest first, RX0 = 1,0,0,1 and RX1 = 0,1,1,0. It decodes as four consecutive 0 data bits.
- R4: A symbol with both wires at 1 raises the both-high flag for one cycle, in the cycle that symbol is decoded.
- R5: RX0 at 1 in two consecutive symbols raises the RX0 repeat flag. The exception is when the second symbol is the first symbol of a recognised substitution group.
- R6: RX1 at 1 in two consecutive symbols raises the RX1 repeat flag. The exception is when the second symbol belongs to a recognised substitution group that is already under way.
- R7: The zero-run flag is raised for each all-zero symbol that ends a run of ZRUN_LIMIT (default 4) or more consecutive all-zero symbols. Substitution symbols break a run.
- R8: The combined error output equals the OR of the four rule flags, in the same cycle.
- R9: While a substitution group is being decoded, no new group can start inside it. A match that overlaps the last symbol of the current group is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx0 | input | 1 | Line wire 0 |
| rx1 | input | 1 | Line wire 1 |
| data_out | output | 1 | Rebuilt serial bit |
| err_any | output | 1 | OR of all rule flags |
| err_both | output | 1 | Both wires high |
| err_rep0 | output | 1 | Repeated 1 on wire 0 |
| err_rep1 | output | 1 | Repeated 1 on wire 1 |
| err_zrun | output | 1 | Zero run of limit length or more |

## Verification
The hardest case to reach is a substitution group whose tail looks like the start of a second group, because this needs an exact seven-symbol sequence. The other hard case is a group that follows a wire-0 one directly, where the exemption rules must decide. Random line noise almost never produces either. The stimulus therefore opens with directed sequences for both cases and for an out-of-group 0,1,1,0 on wire 1. It then mixes random symbols with inserted groups, groups preceded by a wire-0 one, and zero runs of three to six symbols.

// File: rtl/dl_pkg.sv
package dl_pkg;
    localparam int unsigned WIN    = 4;
    localparam int unsigned FILL_W = $clog2(WIN + 1);
    localparam int unsigned CNT_W  = $clog2(WIN);
    localparam logic [WIN-1:0] GRP_W0 = 4'b1001;
    localparam logic [WIN-1:0] GRP_W1 = 4'b0110;

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic [CNT_W-1:0]  left;
        logic              prev_vld;
        logic              prev0;
        logic              prev1;
        logic              dout;
        logic              f_both;
        logic              f_rep0;
        logic              f_rep1;
        logic              f_zrun;
        logic              f_any;
    } dl_state_t;
endpackage

// File: rtl/dl_window.sv
module dl_window #(
    parameter int unsigned LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           din,
    output logic [LEN-1:0] win
);
    logic [LEN-1:0] win_d, win_q;

    always_comb begin
        win_d = {win_q[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign win = win_q;
endmodule

// File: rtl/dl_zrun.sv
module dl_zrun #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic zero_sym,
    output logic hit
);
    localparam int unsigned RW = $clog2(LIMIT + 1);
    localparam logic [RW-1:0] TOP = RW'(LIMIT);

    logic [RW-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        hit   = 1'b0;
        if (step) begin
            if (zero_sym) begin
                hit   = (run_q >= TOP - 1'b1);
                run_d = (run_q == TOP) ? run_q : run_q + 1'b1;
            end else begin
                run_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end
endmodule

// File: rtl/dl_decoder.sv
module dl_decoder
    import dl_pkg::*;
#(
    parameter int unsigned ZRUN_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx0,
    input  logic rx1,
    output logic data_out,
    output logic err_any,
    output logic err_both,
    output logic err_rep0,
    output logic err_rep1,
    output logic err_zrun
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(WIN);

    logic [1:0]     rx_bus;
    logic [WIN-1:0] win [2];

    assign rx_bus = {rx1, rx0};

    // one look-ahead window per wire
    for (genvar g = 0; g < 2; g++) begin : g_wire
        dl_window #(.LEN(WIN)) win_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (rx_bus[g]),
            .win  (win[g])
        );
    end

    dl_state_t st_d, st_q;
    logic      vld, old0, old1, grp_match, start, in_grp, zero_sym, zhit;

    dl_zrun #(.LIMIT(ZRUN_LIMIT)) zrun_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (vld),
        .zero_sym(zero_sym),
        .hit     (zhit)
    );

    always_comb begin
        st_d      = st_q;
        vld       = (st_q.fill == FULL);
        old0      = win[0][WIN-1];
        old1      = win[1][WIN-1];
        grp_match = (win[0] == GRP_W0) && (win[1] == GRP_W1);
        start     = vld && (st_q.left == '0) && grp_match;
        in_grp    = start || (st_q.left != '0);
        zero_sym  = vld && !in_grp && !old0 && !old1;

        if (!vld) st_d.fill = st_q.fill + 1'b1;

        if (start)                 st_d.left = CNT_W'(WIN - 1);
        else if (st_q.left != '0)  st_d.left = st_q.left - 1'b1;

        st_d.dout   = vld && !in_grp && (old0 ^ old1);
        st_d.f_both = vld && old0 && old1;
        st_d.f_rep0 = vld && st_q.prev_vld && st_q.prev0 && old0 && !start;
        st_d.f_rep1 = vld && st_q.prev_vld && st_q.prev1 && old1 && (st_q.left == '0);
        st_d.f_zrun = zhit;
        st_d.f_any  = st_d.f_both | st_d.f_rep0 | st_d.f_rep1 | st_d.f_zrun;

        if (vld) begin
            st_d.prev_vld = 1'b1;
            st_d.prev0    = old0;
            st_d.prev1    = old1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_out = st_q.dout;
    assign err_any  = st_q.f_any;
    assign err_both = st_q.f_both;
    assign err_rep0 = st_q.f_rep0;
    assign err_rep1 = st_q.f_rep1;
    assign err_zrun = st_q.f_zrun;
endmodule

// File: rtl/dl_decoder_chk.sv
module dl_decoder_chk (
    input logic clk,
    input logic rst_n,
    input logic rx0,
    input logic rx1,
    input logic data_out,
    input logic err_any,
    input logic err_both,
    input logic err_rep0,
    input logic err_rep1,
    input logic err_zrun
);
    logic [3:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= '0;
        else if (age_q != 4'hF) age_q <= age_q + 1'b1;
    end

    AST_ANY_NEEDS_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> (err_both || err_rep0 || err_rep1 || err_zrun)); // R8
    AST_RULE_SETS_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_both || err_rep0 || err_rep1 || err_zrun) |-> err_any); // R8
    AST_BOTH_HIGH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 4'd5 && $past(rx0 && rx1, 5)) |-> (err_both && !data_out)); // R4
    AST_ZERO_SYM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 4'd5 && $past(!rx0 && !rx1, 5)) |-> !data_out); // R2
    AST_ZRUN_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        err_zrun |-> ($past(!rx0 && !rx1, 5) && !data_out)); // R7
    AST_REP0_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        err_rep0 |-> ($past(rx0, 5) && $past(rx0, 6))); // R5
    AST_REP1_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        err_rep1 |-> ($past(rx1, 5) && $past(rx1, 6))); // R6
    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q < 4'd5) |-> !(data_out || err_any)); // R1
endmodule

bind dl_decoder dl_decoder_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx0     (rx0),
    .rx1     (rx1),
    .data_out(data_out),
    .err_any (err_any),
    .err_both(err_both),
    .err_rep0(err_rep0),
    .err_rep1(err_rep1),
    .err_zrun(err_zrun)
);

// File: tb/dl_decoder_tb_top.sv
module dl_decoder_tb_top;
    localparam int N = 2500;
    localparam int H = N + 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, rx0, rx1;
    logic data_out, err_any, err_both, err_rep0, err_rep1, err_zrun;

    dl_decoder #(.ZRUN_LIMIT(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx0(rx0), .rx1(rx1),
        .data_out(data_out), .err_any(err_any), .err_both(err_both),
        .err_rep0(err_rep0), .err_rep1(err_rep1), .err_zrun(err_zrun)
    );

    int  errs = 0;
    int  checks = 0;
    int  idx = 0;
    bit  done = 1'b0;
    logic h0 [H];
    logic h1 [H];

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic put(input logic a, input logic b);
        if (idx < H) begin
            h0[idx] = a;
            h1[idx] = b;
            idx++;
        end
    endtask

    task automatic put_grp();
        put(1, 0); put(0, 1); put(0, 1); put(1, 0);
    endtask

    // reference state, advanced once per decoded symbol
    int   m_left = 0;
    int   m_zr = 0;
    logic m_pv = 0, m_p0 = 0, m_p1 = 0;

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < H; i++) begin h0[i] = 0; h1[i] = 0; end
        // directed: overlapping group tail (R9), group after wire-0 one (R5),
        // 0110 on wire 1 outside a group (R6), long zero run (R7), both high (R4)
        put(0, 1); put_grp(); put(0, 1); put(0, 1); put(1, 0);
        put(0, 1); put(1, 0); put_grp(); put(0, 1);
        put(0, 0); put(0, 1); put(0, 1); put(0, 0); put(1, 0);
        for (int k = 0; k < 6; k++) put(0, 0);
        put(1, 1); put(0, 1);
        while (idx < N) begin
            int r;
            r = $urandom % 10;
            case (r)
                0, 1, 2, 3: begin
                    int s;
                    s = $urandom % 3;
                    put(s == 1, s == 2);
                end
                4: put(1, 1);
                5: put_grp();
                6: begin put(1, 0); put_grp(); end
                7: begin
                    int len;
                    len = 3 + ($urandom % 4);
                    for (int k = 0; k < len; k++) put(0, 0);
                end
                8: begin put(0, 1); put(0, 1); end
                default: begin put(1, 0); put(1, 0); end
            endcase
        end
        while (idx < H) begin put(1, 0); put(0, 1); end

        rst_n = 1'b0; rx0 = 1'b0; rx1 = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 data in reset", data_out, 1'b0);
        chk("R1 any in reset", err_any, 1'b0);
        chk("R1 zrun in reset", err_zrun, 1'b0);
        rst_n = 1'b1;
        rx0 = h0[0]; rx1 = h1[0];
        for (int m = 0; m < N + 4; m++) begin
            @(negedge clk);
            if (m < 4) begin
                chk("R1 data during fill", data_out, 1'b0);
                chk("R1 flags during fill", err_any, 1'b0);
            end else begin
                int   j;
                logic det, sub, e_d, e_b, e_r0, e_r1, zs, e_z;
                j   = m - 4;
                det = (m_left == 0) &&
                      h0[j] && !h0[j+1] && !h0[j+2] && h0[j+3] &&
                      !h1[j] && h1[j+1] && h1[j+2] && !h1[j+3];
                sub  = det || (m_left != 0);
                e_d  = !sub && (h0[j] ^ h1[j]);
                e_b  = h0[j] && h1[j];
                e_r0 = m_pv && m_p0 && h0[j] && !det;
                e_r1 = m_pv && m_p1 && h1[j] && (m_left == 0);
                zs   = !sub && !h0[j] && !h1[j];
                e_z  = zs && (m_zr >= 3);
                chk(sub ? "R3 group data (R9 overlap)" : "R2 data", data_out, e_d);
                chk("R4 both-high flag", err_both, e_b);
                chk("R5 wire0 repeat flag", err_rep0, e_r0);
                chk("R6 wire1 repeat flag", err_rep1, e_r1);
                chk("R7 zero-run flag", err_zrun, e_z);
                chk("R8 combined flag", err_any, e_b | e_r0 | e_r1 | e_z);
                m_zr   = zs ? m_zr + 1 : 0;
                m_left = det ? 3 : (m_left != 0 ? m_left - 1 : 0);
                m_pv = 1'b1; m_p0 = h0[j]; m_p1 = h1[j];
            end
            if (m + 1 < H) begin rx0 = h0[m+1]; rx1 = h1[m+1]; end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule